// File: doc/BRIEF.md
# Dual-Pot Register and Instruction Engine

This block carries out already-decoded instructions for a pair of digitally controlled potentiometers. Each pot owns one 6-bit wiper register, which sets the tap position. Each pot also owns a bank of four 6-bit data registers that hold saved positions. A serial front-end presents one instruction at a time. The instruction is a 4-bit opcode, a 2-bit register index, a pot-select bit and an 8-bit data byte, and it is qualified by a one-cycle valid strobe. The engine updates its storage and hands back a padded read byte that the front-end shifts out.

Any write into a data register models a slow nonvolatile write. This covers a host write, a transfer from a wiper, and the transfer that acts on both pots at once. Each such write raises a busy flag for a fixed number of cycles, and every command that arrives while busy is dropped. A load into a wiper behaves like a fast static write, and the new wiper value appears after a short fixed pipeline delay. A stepping mode lets the front-end move one pot's wiper up or down one tap per pulse. The wiper stops at either end of its range.

Top module: `dpot_regfile_engine`

## Requirements
- R1: After reset both wipers, all eight data registers, busy and rd_valid are zero.
- R2: Opcode 4'b1001 returns the wiper of the pot picked by cmd_pot. Opcode 4'b1010 loads that wiper from cmd_data[5:0]. The new wiper value shows on the wiper output exactly LOAD_DLY clock edges after the accepting edge.
- R3: Opcode 4'b1011 returns data register cmd_reg of pot cmd_pot. Opcode 4'b1100 writes cmd_data[5:0] into that register and leaves the other seven unchanged.
- R4: Opcode 4'b1101 loads the selected pot's wiper from its data register cmd_reg, with the same LOAD_DLY delay as R2.
- R5: Opcode 4'b1110 copies the selected pot's wiper into its data register cmd_reg.
- R6: Opcode 4'b0001 loads each pot's wiper from that pot's own data register cmd_reg. cmd_pot has no effect on this opcode.
- R7: Opcode 4'b1000 copies each pot's wiper into that pot's own data register cmd_reg. cmd_pot has no effect on this opcode.
- R8: An accepted 4'b1100, 4'b1110 or 4'b1000 raises busy on the next cycle. Busy stays high for exactly NV_CYCLES cycles. Any command presented while busy is ignored: it returns no read and changes no register.
- R9: The opcodes 4'b0000, 4'b0011 to 4'b0111 and 4'b1111 are ignored. They leave every register unchanged, return no read and do not raise busy.
- R10: Opcode 4'b0010 enters stepping mode for pot cmd_pot. In that mode each step_valid pulse moves the wiper one tap, up when step_up is 1 and down when it is 0. The wiper holds at 63 going up and at 0 going down. The next accepted command ends stepping mode. step_valid has no effect outside stepping mode.
- R11: For a read opcode, rd_valid pulses on the cycle after the accepting edge. rd_data then holds {2'b00, value}. On writes, cmd_data[7:6] is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle instruction strobe |
| cmd_op | input | 4 | Opcode |
| cmd_reg | input | 2 | Data register index |
| cmd_pot | input | 1 | Pot select |
| cmd_data | input | 8 | Data byte for write opcodes |
| step_valid | input | 1 | One-tap step pulse |
| step_up | input | 1 | Step direction, 1 = toward top |
| busy | output | 1 | Nonvolatile write in progress |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte, two zero MSBs |
| wiper0 | output | 6 | Pot 0 tap position |
| wiper1 | output | 6 | Pot 1 tap position |

## Verification
Random instruction streams mix all nine legal opcodes with the undefined ones. The register indices, pot bits and data bytes are random, and cmd_data[7:6] is set to garbage. A shadow model compares every read and both wipers, so a swapped pot, a wrong register index or a global opcode that touches only one pot shows up as a mismatch.

Directed cases cover the rest:
- The exact cycle a wiper load lands, which separates an off-by-one delay.
- The busy window length, together with a read probe inside it, which shows whether commands are really dropped.
- Stepping into both ends of the range, which shows saturation.
- A step pulse after stepping mode has ended, which must leave the wiper alone.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int VAL_W = 6;
  localparam int NREG  = 4;

  typedef enum logic [3:0] {
    OP_G_DR2W = 4'b0001,
    OP_STEP   = 4'b0010,
    OP_G_W2DR = 4'b1000,
    OP_RD_W   = 4'b1001,
    OP_WR_W   = 4'b1010,
    OP_RD_D   = 4'b1011,
    OP_WR_D   = 4'b1100,
    OP_DR2W   = 4'b1101,
    OP_W2DR   = 4'b1110
  } opcode_e;

  typedef struct packed {
    logic accept;
    logic rd_w;
    logic rd_d;
    logic ld_host;
    logic ld_dr;
    logic dr_host;
    logic dr_wiper;
    logic both;
    logic step;
  } dec_t;

  // saturating one-tap move
  function automatic logic [VAL_W-1:0] step_next(input logic [VAL_W-1:0] v, input logic up);
    if (up) return (v == {VAL_W{1'b1}}) ? v : v + 1'b1;
    else    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [7:0] pad_byte(input logic [VAL_W-1:0] v);
    return {{(8-VAL_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/dpot_decode.sv
module dpot_decode
  import dpot_pkg::*;
(
  input  logic       valid,
  input  logic       busy,
  input  logic [3:0] op,
  output dec_t       d
);
  logic legal;
  always_comb begin
    d = '0;
    legal = 1'b1;
    case (op)
      OP_RD_W:   d.rd_w = 1'b1;
      OP_WR_W:   d.ld_host = 1'b1;
      OP_RD_D:   d.rd_d = 1'b1;
      OP_WR_D:   d.dr_host = 1'b1;
      OP_DR2W:   d.ld_dr = 1'b1;
      OP_W2DR:   d.dr_wiper = 1'b1;
      OP_G_DR2W: begin d.ld_dr = 1'b1; d.both = 1'b1; end
      OP_G_W2DR: begin d.dr_wiper = 1'b1; d.both = 1'b1; end
      OP_STEP:   d.step = 1'b1;
      default:   legal = 1'b0;
    endcase
    d.accept = valid & ~busy & legal;
  end
endmodule

// File: rtl/dpot_nvtimer.sv
module dpot_nvtimer #(
  parameter int NV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(NV_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);

  // R8: a start always reloads the full window
  p_busy_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt == CW'(NV_CYCLES)));
  // R8: the window only shrinks by one per cycle
  p_busy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dpot_pot.sv
module dpot_pot
  import dpot_pkg::*;
#(
  parameter int LOAD_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic [VAL_W-1:0] ld_val,
  input  logic             dr_we,
  input  logic [1:0]       dr_idx,
  input  logic [VAL_W-1:0] dr_wval,
  input  logic             step_go,
  input  logic             step_up,
  output logic [VAL_W-1:0] wiper,
  output logic [VAL_W-1:0] dr_rd
);
  logic [NREG-1:0][VAL_W-1:0]     dreg;
  logic [LOAD_DLY-1:0]            pv;
  logic [LOAD_DLY-1:0][VAL_W-1:0] pd;
  logic                           land;

  assign land  = pv[LOAD_DLY-1];
  assign dr_rd = dreg[dr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      pd <= '0;
    end else begin
      pv[0] <= ld_req;
      pd[0] <= ld_val;
      for (int i = 1; i < LOAD_DLY; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wiper <= '0;
    else if (land)    wiper <= pd[LOAD_DLY-1];
    else if (step_go) wiper <= step_next(wiper, step_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dreg <= '0;
    else if (dr_we) dreg[dr_idx] <= dr_wval;
  end

  // R2: without a landing load or a step the wiper holds
  p_wiper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!land && !step_go) |=> $stable(wiper));
  // R10: stepping up at the top end stays at the top
  p_step_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && step_up && !land && wiper == {VAL_W{1'b1}}) |=> (wiper == {VAL_W{1'b1}}));
  // R10: stepping down at zero stays at zero
  p_step_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !step_up && !land && wiper == '0) |=> (wiper == '0));
  // R3: data bank holds while no write is requested
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_we |=> $stable(dreg));
endmodule

// File: rtl/dpot_regfile_engine.sv
module dpot_regfile_engine
  import dpot_pkg::*;
#(
  parameter int NV_CYCLES = 20,
  parameter int LOAD_DLY  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  input  logic [1:0] cmd_reg,
  input  logic       cmd_pot,
  input  logic [7:0] cmd_data,
  input  logic       step_valid,
  input  logic       step_up,
  output logic       busy,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic [5:0] wiper0,
  output logic [5:0] wiper1
);
  localparam int NPOT = 2;

  dec_t                       d;
  logic                       nv_start;
  logic                       step_on;
  logic                       step_pot;
  logic [NPOT-1:0][VAL_W-1:0] wip;
  logic [NPOT-1:0][VAL_W-1:0] drv;

  dpot_decode u_dec (.valid(cmd_valid), .busy(busy), .op(cmd_op), .d(d));

  assign nv_start = d.accept & (d.dr_host | d.dr_wiper);

  dpot_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_nv (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy));

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic sel;
    assign sel = d.both | (cmd_pot == 1'(p));
    dpot_pot #(.LOAD_DLY(LOAD_DLY)) u_pot (
      .clk(clk), .rst_n(rst_n),
      .ld_req (d.accept & sel & (d.ld_host | d.ld_dr)),
      .ld_val (d.ld_host ? cmd_data[VAL_W-1:0] : drv[p]),
      .dr_we  (d.accept & sel & (d.dr_host | d.dr_wiper)),
      .dr_idx (cmd_reg),
      .dr_wval(d.dr_host ? cmd_data[VAL_W-1:0] : wip[p]),
      .step_go(step_valid & step_on & (step_pot == 1'(p))),
      .step_up(step_up),
      .wiper  (wip[p]),
      .dr_rd  (drv[p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_on  <= 1'b0;
      step_pot <= 1'b0;
    end else if (d.accept) begin
      step_on  <= d.step;
      step_pot <= cmd_pot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= d.accept & (d.rd_w | d.rd_d);
      if (d.accept & (d.rd_w | d.rd_d))
        rd_data <= pad_byte(d.rd_w ? wip[cmd_pot] : drv[cmd_pot]);
    end
  end

  assign wiper0 = wip[0];
  assign wiper1 = wip[1];

  // R11: read byte always carries two zero MSBs
  p_rd_pad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[7:6] == 2'b00));
  // R8: nothing is accepted while busy
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !rd_valid);
  // R8: busy can only rise after a data-register write is accepted
  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(nv_start));
  // R9: undefined opcodes give no read and no busy
  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_op == 4'b0000 || cmd_op == 4'b1111 ||
      (cmd_op >= 4'b0011 && cmd_op <= 4'b0111))) |=> (!rd_valid && !$rose(busy)));
endmodule

// File: tb/dpot_regfile_engine_bench.sv
module dpot_regfile_engine_bench;
  localparam int NV = 20;
  localparam int LD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_pot = 1'b0, step_valid = 1'b0, step_up = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_reg = '0;
  logic [7:0] cmd_data = '0;
  logic busy, rd_valid;
  logic [7:0] rd_data;
  logic [5:0] wiper0, wiper1;

  int n_chk = 0, n_bad = 0;
  logic [5:0] mw [2];
  logic [5:0] md [2][4];
  logic m_step_on;
  logic m_step_pot;

  always #2.5 clk = ~clk;

  dpot_regfile_engine #(.NV_CYCLES(NV), .LOAD_DLY(LD)) u_dpot_regfile_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
    .step_valid(step_valid), .step_up(step_up), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1));

  function automatic logic [5:0] mv(input logic [5:0] v, input logic up);
    int t;
    t = int'(v) + (up ? 1 : -1);
    if (t > 63) t = 63;
    if (t < 0) t = 0;
    return 6'(t);
  endfunction

  function automatic bit is_legal(input logic [3:0] op);
    return op inside {4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
                      4'b1011, 4'b1100, 4'b1101, 4'b1110};
  endfunction

  function automatic bit is_nv(input logic [3:0] op);
    return op inside {4'b1100, 4'b1110, 4'b1000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_wipers(input string req);
    chk(req, {26'd0, wiper0}, {26'd0, mw[0]});
    chk(req, {26'd0, wiper1}, {26'd0, mw[1]});
  endtask

  // drives one command; returns at the negedge after the accepting edge
  task automatic do_cmd(input logic [3:0] op, input logic [1:0] r, input logic p, input logic [7:0] dat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_pot = p; cmd_data = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic model(input logic [3:0] op, input logic [1:0] r, input logic p, input logic [7:0] dat);
    if (!is_legal(op)) return;
    m_step_on = (op == 4'b0010);
    m_step_pot = p;
    case (op)
      4'b1010: mw[p] = dat[5:0];
      4'b1100: md[p][r] = dat[5:0];
      4'b1101: mw[p] = md[p][r];
      4'b1110: md[p][r] = mw[p];
      4'b0001: begin mw[0] = md[0][r]; mw[1] = md[1][r]; end
      4'b1000: begin md[0][r] = mw[0]; md[1][r] = mw[1]; end
      default: ;
    endcase
  endtask

  // full command with read check, model update and busy handling
  task automatic run_cmd(input logic [3:0] op, input logic [1:0] r, input logic p, input logic [7:0] dat);
    logic [7:0] expv;
    bit rd;
    rd = (op == 4'b1001) || (op == 4'b1011);
    expv = {2'b00, (op == 4'b1001) ? mw[p] : md[p][r]};
    do_cmd(op, r, p, dat);
    if (rd) chk("R11 read", {24'd0, rd_valid, rd_data}, {24'd0, 1'b1, expv});
    else    chk("R9 no read", {31'd0, rd_valid}, 32'd0);
    if (!is_legal(op)) chk("R9 no busy", {31'd0, busy}, 32'd0);
    model(op, r, p, dat);
    if (is_nv(op)) wait_busy();
    else repeat (LD + 1) @(negedge clk);
  endtask

  // counts the busy window and probes a read inside it
  task automatic wait_busy();
    int n = 0;
    while (busy && n < NV + 5) begin
      n++;
      if (n == 2) begin
        cmd_valid = 1'b1; cmd_op = 4'b1001; cmd_pot = 1'b0;
      end
      if (n == 3) begin
        chk("R8 dropped while busy", {31'd0, rd_valid}, 32'd0);
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R8 busy length", n, NV);
    m_step_on = m_step_on;
    repeat (LD) @(negedge clk);
  endtask

  task automatic pulse(input logic up);
    @(negedge clk);
    step_valid = 1'b1; step_up = up;
    @(negedge clk);
    step_valid = 1'b0;
    if (m_step_on) mw[m_step_pot] = mv(mw[m_step_pot], up);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd1234));
        for (int pp = 0; pp < 2; pp++) begin
          mw[pp] = '0;
          for (int rr = 0; rr < 4; rr++) md[pp][rr] = '0;
        end
        m_step_on = 1'b0; m_step_pot = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 0);
        chk_wipers("R1 wipers");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_cmd(4'b1011, 2'd3, 1'b1, 8'h00);   // R1 data reg zero

        // R2 exact landing cycle
        do_cmd(4'b1010, 2'd0, 1'b0, 8'hEA);      // garbage top bits, R11
        repeat (LD - 1) @(negedge clk);
        chk("R2 wiper not yet", {26'd0, wiper0}, 0);
        @(negedge clk);
        chk("R2 wiper landed", {26'd0, wiper0}, 6'h2A);
        model(4'b1010, 2'd0, 1'b0, 8'hEA);
        run_cmd(4'b1001, 2'd0, 1'b0, 8'h00);   // R2 read back

        // R3 write then R5 copy, R4 load, R6/R7 globals
        run_cmd(4'b1100, 2'd2, 1'b1, 8'hD5);
        run_cmd(4'b1011, 2'd2, 1'b1, 8'h00);
        run_cmd(4'b1011, 2'd2, 1'b0, 8'h00);   // R3 other pot untouched
        run_cmd(4'b1101, 2'd2, 1'b1, 8'h00);   // R4
        chk_wipers("R4 load");
        run_cmd(4'b1110, 2'd1, 1'b0, 8'h00);   // R5
        run_cmd(4'b1011, 2'd1, 1'b0, 8'h00);
        run_cmd(4'b1000, 2'd3, 1'b1, 8'h00);   // R7 pot bit ignored
        run_cmd(4'b1011, 2'd3, 1'b0, 8'h00);
        run_cmd(4'b1011, 2'd3, 1'b1, 8'h00);
        run_cmd(4'b0001, 2'd2, 1'b1, 8'h00);   // R6
        chk_wipers("R6 global load");

        // R10 stepping and saturation
        run_cmd(4'b1010, 2'd0, 1'b1, 8'h3E);
        run_cmd(4'b0010, 2'd0, 1'b1, 8'h00);
        for (int k = 0; k < 3; k++) pulse(1'b1);
        chk_wipers("R10 top hold");
        run_cmd(4'b1010, 2'd0, 1'b0, 8'h01);
        run_cmd(4'b0010, 2'd0, 1'b0, 8'h00);
        for (int k = 0; k < 3; k++) pulse(1'b0);
        chk_wipers("R10 floor hold");
        run_cmd(4'b1001, 2'd0, 1'b1, 8'h00);   // ends stepping mode
        pulse(1'b1);
        chk_wipers("R10 step ignored outside mode");

        // R9 undefined opcodes
        run_cmd(4'b1111, 2'd1, 1'b0, 8'h11);
        run_cmd(4'b0101, 2'd2, 1'b1, 8'h22);
        chk_wipers("R9 wipers unchanged");

        // random mix
        for (int it = 0; it < 400; it++) begin
          logic [3:0] op;
          op = 4'($urandom_range(0, 15));
          run_cmd(op, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom));
          if (op == 4'b0010)
            for (int k = 0; k < 4; k++) pulse(1'($urandom_range(0, 1)));
          if (it % 8 == 0) chk_wipers("R2 R4 R6 R10 random wipers");
        end
        for (int pp = 0; pp < 2; pp++)
          for (int rr = 0; rr < 4; rr++)
            run_cmd(4'b1011, 2'(rr), 1'(pp), 8'h00);   // R3 R5 R7 final bank
        chk_wipers("R2 final wipers");
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule